// File: doc/BRIEF.md
# Oversampling Serial Receiver with Majority Vote

This block turns an asynchronous serial line into bytes. A free-running oversample enable, produced outside the block, paces every decision. The line is first passed through a synchroniser. While idle, the receiver hunts for a low level on each enable. When it finds one, it checks the candidate start bit part-way into the bit and restarts its own bit-rate counter from that point. Every later bit is then decided near its middle from the three most recent samples.

The character format is set by three static configuration inputs: samples per bit minus one, character length (6, 7 or 8 bits), and parity mode (none, even, odd, forced zero or forced one). These inputs must not change while a character is being received. Finished characters leave through a valid/ready output. Valid stays high with the byte held steady until ready is seen high, and ready low stands for a full receive queue. Parity, framing and overrun events come out as one-cycle pulses, together with a pulse for each accepted start bit. The receiver needs no stop-bit setting: it checks the first stop bit only and then resumes hunting at once, so frames with 1, 1.5 or 2 stop bits are all accepted.

Top module: `uart_os_rx`

## Requirements
- R1: The line is looked at only on cycles with `sample_en` high. In idle, a synchronised low sample on such a cycle opens a start candidate. `cfg_div` (at least 7) gives samples per bit minus one.
- R2: A candidate waits `cfg_div/2` (rounded down) enables and then takes three more samples. If any of the three is high, the receiver returns to idle with no pulse and no character.
- R3: `start_seen` pulses for exactly one cycle for each accepted start bit.
- R4: After the start is accepted, each bit is decided every `cfg_div+1` enables as the 2-of-3 majority of the latest three samples. A single wrong sample inside a bit does not change the byte.
- R5: Data bits arrive least significant first. The length is set by `cfg_len`: 0 gives 6 bits, 1 gives 7 bits, 2 or 3 give 8 bits. `out_data` is right-aligned with the unused upper bits at zero.
- R6: `cfg_parity` selects the parity mode: 0 none, 1 even, 2 odd, 3 forced 0, 4 forced 1, and 5 to 7 are treated as none. When the received parity bit differs from the expected one, `err_parity` pulses at the end of the character. With no parity there is never a parity pulse.
- R7: If the first stop bit is sampled low, `err_frame` pulses and the character is still delivered. Hunting for the next start resumes right after the first stop bit.
- R8: Once `out_valid` is high it stays high, with `out_data` steady, until a cycle with `out_ready` high. That cycle completes the transfer.
- R9: If a start is accepted while a held character is still waiting (`out_valid` high and `out_ready` low), `err_overrun` pulses. A new character that completes while the old one still waits is discarded, and the held one is kept.
- R10: After reset `out_valid` and all pulse outputs are low. The line is assumed idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Oversample enable, one cycle per sample |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| cfg_div | input | DIV_W | Samples per bit minus one (at least 7) |
| cfg_len | input | 2 | Character length code |
| cfg_parity | input | 3 | Parity mode code |
| out_valid | output | 1 | A received character is held |
| out_ready | input | 1 | Downstream can take the character (low means full) |
| out_data | output | 8 | Received character, right-aligned |
| start_seen | output | 1 | Pulse for each accepted start bit |
| err_parity | output | 1 | Pulse for a parity mismatch |
| err_frame | output | 1 | Pulse for a low first stop bit |
| err_overrun | output | 1 | Pulse for a start accepted while a character is waiting |

## Verification
The main path is driven with a table of frames that covers every length, every parity mode, and two oversample ratios. Wrong-parity and low-stop frames in the table separate a correct parity or framing check from one that is stuck or inverted. Separate runs cover the following: a short low glitch on an idle line, which tells start validation apart from simple edge detection; one-sample glitches in the middle of a data bit, which prove the vote is used rather than a single sample; a half-rate enable, which shows the timing counts enables and not clocks; an out-of-range parity code, which must act as no parity; and a back-pressure run in which a second frame arrives while the first is held, which distinguishes keeping the old byte from overwriting it and makes the overrun pulse appear.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  localparam int CHAR_MAX = 8;
  localparam int IDX_W    = 4;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_SPACE = 3'd3,
    PAR_MARK  = 3'd4
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HALF,
    ST_CONF,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  // number of data bits for a length code
  function automatic logic [IDX_W-1:0] char_bits(input logic [1:0] code);
    case (code)
      2'd0:    char_bits = IDX_W'(6);
      2'd1:    char_bits = IDX_W'(7);
      default: char_bits = IDX_W'(8);
    endcase
  endfunction

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_os_rx_vote.sv
module uart_os_rx_vote (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic maj
);
  logic [1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hist <= 2'b11;
    else if (tick) hist <= {hist[0], din};
  end

  // 2-of-3 over the two stored samples and the current one
  assign maj = (hist[0] & hist[1]) | (hist[0] & din) | (hist[1] & din);
endmodule

// File: rtl/uart_os_rx_timer.sv
module uart_os_rx_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [DIV_W-1:0] div,
  output logic [DIV_W-1:0] cnt,
  output logic             bit_tick
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (tick)  cnt <= (cnt == div) ? '0 : cnt + DIV_W'(1);
  end

  assign bit_tick = tick && !clear && (cnt == div);
endmodule

// File: rtl/uart_os_rx_hold.sv
module uart_os_rx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         busy
);
  assign busy = out_valid && !out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load && !busy) begin
      out_valid <= 1'b1;
      out_data  <= din;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_DROP_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && busy) |=> $stable(out_data)); // R9
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             rx_serial,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_len,
  input  logic [2:0]       cfg_parity,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             start_seen,
  output logic             err_parity,
  output logic             err_frame,
  output logic             err_overrun
);
  localparam int CW = CHAR_MAX;

  rx_state_e        state;
  logic             rx_s, maj;
  logic [DIV_W-1:0] cnt, half_m1;
  logic             bit_tick, tmr_clear;
  logic [1:0]       conf_cnt;
  logic [IDX_W-1:0] bit_idx, nbits;
  logic [CW-1:0]    shreg, aligned;
  logic             par_acc, par_bad, par_on, par_exp;
  logic             start_ok, done, hold_busy;

  uart_os_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_serial), .dout(rx_s));

  uart_os_rx_vote u_vote (
    .clk(clk), .rst_n(rst_n), .tick(sample_en), .din(rx_s), .maj(maj));

  uart_os_rx_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(sample_en), .clear(tmr_clear),
    .div(cfg_div), .cnt(cnt), .bit_tick(bit_tick));

  uart_os_rx_hold #(.W(CW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(done), .din(aligned),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .busy(hold_busy));

  assign nbits   = char_bits(cfg_len);
  assign half_m1 = (cfg_div >> 1) - DIV_W'(1);

  always_comb begin
    par_on  = 1'b1;
    par_exp = 1'b0;
    case (cfg_parity)
      PAR_EVEN:  par_exp = par_acc;
      PAR_ODD:   par_exp = ~par_acc;
      PAR_SPACE: par_exp = 1'b0;
      PAR_MARK:  par_exp = 1'b1;
      default:   par_on  = 1'b0;
    endcase
  end

  assign start_ok  = (state == ST_CONF) && sample_en && !rx_s && (conf_cnt == 2'd2);
  assign tmr_clear = ((state == ST_IDLE) && sample_en && !rx_s) || start_ok;
  assign done      = (state == ST_STOP) && bit_tick;
  assign aligned   = shreg >> (IDX_W'(CW) - nbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      conf_cnt    <= '0;
      bit_idx     <= '0;
      shreg       <= '0;
      par_acc     <= 1'b0;
      par_bad     <= 1'b0;
      start_seen  <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      start_seen  <= start_ok;
      err_overrun <= start_ok && hold_busy;
      err_parity  <= done && par_bad;
      err_frame   <= done && !maj;
      case (state)
        ST_IDLE: if (sample_en && !rx_s) state <= ST_HALF;
        ST_HALF: if (sample_en && cnt == half_m1) begin
          state    <= ST_CONF;
          conf_cnt <= '0;
        end
        ST_CONF: if (sample_en) begin
          if (rx_s) begin
            state <= ST_IDLE;
          end else if (conf_cnt == 2'd2) begin
            state   <= ST_DATA;
            bit_idx <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            par_bad <= 1'b0;
          end else begin
            conf_cnt <= conf_cnt + 2'd1;
          end
        end
        ST_DATA: if (bit_tick) begin
          shreg   <= {maj, shreg[CW-1:1]};
          par_acc <= par_acc ^ maj;
          bit_idx <= bit_idx + IDX_W'(1);
          if (bit_idx == nbits - IDX_W'(1))
            state <= par_on ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (bit_tick) begin
          par_bad <= (maj != par_exp);
          state   <= ST_STOP;
        end
        ST_STOP: if (bit_tick) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> !start_seen); // R3
  AST_PARITY_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity |-> (cfg_parity >= 3'd1 && cfg_parity <= 3'd4)); // R6
  AST_END_NOT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity || err_frame) |-> !start_seen); // R7
  AST_OVERRUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |-> out_valid); // R9
  AST_DATA_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data >> nbits) == 8'd0)); // R5
endmodule

// File: tb/uart_os_rx_bench.sv
module uart_os_rx_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, sample_en, rx_serial, out_ready;
  logic [7:0] cfg_div;
  logic [1:0] cfg_len;
  logic [2:0] cfg_parity;
  logic       out_valid, start_seen, err_parity, err_frame, err_overrun;
  logic [7:0] out_data;

  uart_os_rx u_uart_os_rx (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rx_serial(rx_serial),
    .cfg_div(cfg_div), .cfg_len(cfg_len), .cfg_parity(cfg_parity),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .start_seen(start_seen), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun));

  int total = 0, bad = 0;
  int en_div = 1, en_ph = 0;
  int n_start, n_got;
  bit f_pe, f_fe, f_ovr, finished = 0;
  logic [7:0] got_d;

  // fields: len[15:14] par[13:11] badpar[10] stop[9] slow[8] data[7:0]
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    {2'd2, 3'd0, 1'b0, 1'b1, 1'b0, 8'hA5},
    {2'd2, 3'd1, 1'b0, 1'b1, 1'b1, 8'h3C},
    {2'd1, 3'd2, 1'b0, 1'b1, 1'b0, 8'h5A},
    {2'd0, 3'd3, 1'b1, 1'b1, 1'b0, 8'hFF},
    {2'd2, 3'd4, 1'b0, 1'b1, 1'b1, 8'h01},
    {2'd2, 3'd1, 1'b0, 1'b0, 1'b0, 8'h81},
    {2'd0, 3'd0, 1'b0, 1'b1, 1'b1, 8'h2B},
    {2'd1, 3'd1, 1'b1, 1'b1, 1'b0, 8'h7E}
  };

  always @(negedge clk) begin
    en_ph = (en_ph + 1) % en_div;
    sample_en = (en_ph == 0);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_seen)  n_start++;
      if (err_parity)  f_pe = 1;
      if (err_frame)   f_fe = 1;
      if (err_overrun) f_ovr = 1;
      if (out_valid && out_ready) begin n_got++; got_d = out_data; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    n_start = 0; n_got = 0; f_pe = 0; f_fe = 0; f_ovr = 0; got_d = 8'h00;
  endtask

  task automatic put_bit(input logic v, input int bc, input bit g);
    rx_serial = v;
    if (g) begin
      repeat (bc / 2) @(negedge clk);
      rx_serial = ~v;
      @(negedge clk);
      rx_serial = v;
      repeat (bc - bc / 2 - 1) @(negedge clk);
    end else begin
      repeat (bc) @(negedge clk);
    end
  endtask

  task automatic send_frame(input int bc, input int nb, input logic [2:0] par,
                            input logic [7:0] d, input bit badpar, input bit stopv,
                            input int gbit);
    logic pb;
    logic [7:0] m;
    m = d & (8'hFF >> (8 - nb));
    put_bit(1'b0, bc, 1'b0);
    for (int k = 0; k < nb; k++) put_bit(d[k], bc, k == gbit);
    if (par >= 3'd1 && par <= 3'd4) begin
      case (par)
        3'd1:    pb = ^m;
        3'd2:    pb = ~^m;
        3'd3:    pb = 1'b0;
        default: pb = 1'b1;
      endcase
      put_bit(pb ^ badpar, bc, 1'b0);
    end
    put_bit(stopv, bc, 1'b0);
    rx_serial = 1'b1;
    repeat (3 * bc) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int nb;
    logic [7:0] ed;
    rst_n = 1'b0; rx_serial = 1'b1; out_ready = 1'b1; sample_en = 1'b1;
    cfg_div = 8'd7; cfg_len = 2'd2; cfg_parity = 3'd0;
    clr();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!out_valid, "R10 valid after reset", out_valid, 0);
    check({start_seen, err_parity, err_frame, err_overrun} == 4'b0,
          "R10 pulses after reset", {start_seen, err_parity, err_frame, err_overrun}, 0);

    // table of frames: R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      cfg_len = v[15:14]; cfg_parity = v[13:11]; cfg_div = v[8] ? 8'd15 : 8'd7;
      nb = (v[15:14] == 2'd0) ? 6 : (v[15:14] == 2'd1) ? 7 : 8;
      ed = v[7:0] & (8'hFF >> (8 - nb));
      repeat (4) @(negedge clk);
      clr();
      send_frame(v[8] ? 16 : 8, nb, v[13:11], v[7:0], v[10], v[9], -1);
      check(n_got == 1, "R5 one char per frame", n_got, 1);
      check(got_d == ed, "R5 char value", got_d, ed);
      check(f_pe == (v[10] && v[13:11] != 3'd0), "R6 parity pulse", f_pe,
            (v[10] && v[13:11] != 3'd0));
      check(f_fe == !v[9], "R7 frame pulse", f_fe, !v[9]);
      check(n_start == 1, "R3 one start per frame", n_start, 1);
    end

    // R2 short low glitch is rejected
    cfg_len = 2'd2; cfg_parity = 3'd0; cfg_div = 8'd15;
    clr();
    rx_serial = 1'b0; repeat (3) @(negedge clk); rx_serial = 1'b1;
    repeat (60) @(negedge clk);
    check(n_start == 0 && n_got == 0, "R2 glitch gives no start", n_start + n_got, 0);
    check(!f_pe && !f_fe && !f_ovr, "R2 glitch gives no error", {f_pe, f_fe, f_ovr}, 0);

    // R4 single-sample glitches inside data bits
    cfg_div = 8'd7;
    clr();
    send_frame(8, 8, 3'd0, 8'h00, 1'b0, 1'b1, 3);
    check(got_d == 8'h00 && n_got == 1, "R4 vote rejects high glitch", got_d, 8'h00);
    clr();
    send_frame(8, 8, 3'd0, 8'hFF, 1'b0, 1'b1, 5);
    check(got_d == 8'hFF && n_got == 1, "R4 vote rejects low glitch", got_d, 8'hFF);

    // R6 out-of-range parity code acts as none
    cfg_parity = 3'd6;
    clr();
    send_frame(8, 8, 3'd0, 8'h96, 1'b0, 1'b1, -1);
    check(got_d == 8'h96 && !f_pe, "R6 code 6 means no parity", got_d, 8'h96);
    cfg_parity = 3'd0;

    // R1 half-rate enable, timing follows enables
    en_div = 2;
    clr();
    send_frame(16, 8, 3'd0, 8'hC3, 1'b0, 1'b1, -1);
    check(got_d == 8'hC3 && n_got == 1, "R1 gated enable char", got_d, 8'hC3);
    en_div = 1;
    repeat (4) @(negedge clk);

    // R8 R9 back-pressure and overrun
    out_ready = 1'b0;
    clr();
    send_frame(8, 8, 3'd0, 8'h11, 1'b0, 1'b1, -1);
    check(out_valid && out_data == 8'h11, "R8 held char", out_data, 8'h11);
    send_frame(8, 8, 3'd0, 8'h22, 1'b0, 1'b1, -1);
    check(f_ovr, "R9 overrun pulse", f_ovr, 1);
    check(out_valid && out_data == 8'h11, "R9 old char kept", out_data, 8'h11);
    check(n_got == 0, "R8 no transfer while not ready", n_got, 0);
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    check(n_got == 1 && got_d == 8'h11, "R8 transfer on ready", got_d, 8'h11);
    repeat (20) @(negedge clk);
    check(n_got == 1 && !out_valid, "R9 new char discarded", n_got, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule